// File: doc/BRIEF.md
# PIO Sector Transfer Sequencer

This block is the device-side sequencer that carries out multi-sector programmed-I/O commands of a disk task file: sector read, sector read-verify and sector write. When a command is accepted it loads the starting sector count and the cylinder/head/sector address. For every sector it then requests the media operation from a disk-side model, hands the 16-bit data port over to the host for one sector's worth of words, and moves the task-file address on by one sector. It drives the busy, data-request, interrupt and error flags that the host polls or waits on.

The host side shows up as single-cycle pulses: a command strobe with a kind code, data-port read and write pulses, and a status-read pulse that acknowledges the interrupt. The disk side asks for work with a level request and gets a one-cycle completion pulse, which can carry an error. The buffer word address counts the words moved within the current sector, so an external sector buffer can be indexed with it.

Top module: `pio_sector_seq`

## Requirements
- R1: A start sector count of 0 means 256 sectors. The count output drops by one as each sector completes without error, and it reads 0 after a command that completes without error.
- R2: Read (kind code 0) sets busy on accept with data-request clear. At each media completion it clears busy, sets data-request and raises the interrupt. After the host has read the sector it clears data-request and sets busy again, except after the last sector.
- R3: Write (kind code 2) sets data-request on accept with no interrupt. After each sector is filled it clears data-request and sets busy. When a sector is committed and more remain, it clears busy, sets data-request and interrupts. After the last commit it clears busy and interrupts with data-request clear.
- R4: Read-verify (kind code 1) holds busy and never sets data-request. It raises the interrupt only once, when busy clears at the end.
- R5: A media error ends the command at the failing sector and sets the error flag together with the interrupt. The address outputs keep that sector's address and the count holds the sectors still outstanding, the failing one included. On a read error the failing sector is still offered with data-request and the interrupt.
- R6: After a command that completes without error, the address outputs hold the address of the last sector transferred, and they stay unchanged until the next command.
- R7: The sector number advances from 1 up to the sectors-per-track limit and then wraps to 1 while the head increments. Past the head limit the head wraps to 0 and the 16-bit cylinder increments.
- R8: One sector is 256 data-port accesses. The buffer word address gives the index of the next word within the sector, starting at 0.
- R9: Data-port accesses are ignored, and leave the word address unchanged, when data-request is clear or when their direction does not match the command.
- R10: A command strobe is ignored while busy or data-request is set, and a command with kind code 3 is always ignored.
- R11: A status-read pulse or an accepted command clears the interrupt. When an interrupt is raised in the same cycle as a status read, the interrupt is set.
- R12: After reset, busy, data-request, interrupt, error, the count, the address outputs and the word address are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdKind | input | 2 | 0 read, 1 read-verify, 2 write, 3 none |
| startSecCnt | input | SEC_W | Sectors to move; 0 means 256 |
| startSector | input | SEC_W | First sector number |
| startHead | input | HEAD_W | First head |
| startCyl | input | CYL_W | First cylinder |
| maxSector | input | SEC_W | Sectors per track (highest sector number) |
| maxHead | input | HEAD_W | Highest head number |
| portRd | input | 1 | Host data-port read pulse |
| portWr | input | 1 | Host data-port write pulse |
| statusRd | input | 1 | Host status read, acknowledges interrupt |
| mediaDone | input | 1 | Disk side finished the requested sector |
| mediaErr | input | 1 | Qualifies mediaDone as failed |
| mediaReq | output | 1 | Asks the disk side to process the current sector |
| busy | output | 1 | Device owns the task file |
| drq | output | 1 | Data port open for the current sector |
| intrq | output | 1 | Interrupt to host |
| errFlag | output | 1 | Last command ended in error |
| secCntOut | output | SEC_W | Sectors remaining |
| sectorOut | output | SEC_W | Current sector number |
| headOut | output | HEAD_W | Current head |
| cylOut | output | CYL_W | Current cylinder |
| bufAddr | output | log2(WORDS_PER_SECTOR) | Word index within the sector |

## Verification
Two functions can land in the same clock edge: the sequencer raising the interrupt at a media completion, and the host clearing it with a status read. The bench drives the status-read pulse in the very cycle of a media completion, then expects the interrupt to read as set. It then sends a lone status read and expects the interrupt to fall. The other collision is a command strobe that arrives during a transfer. It is judged by the flags and the count at the ports staying those of the running command.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    KIND_READ   = 2'd0,
    KIND_VERIFY = 2'd1,
    KIND_WRITE  = 2'd2,
    KIND_NONE   = 2'd3
  } cmdKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_MEDIA,
    ST_RD_XFER,
    ST_WR_XFER,
    ST_WR_MEDIA,
    ST_VF_MEDIA
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture start values, clear word counter
    logic wordStep;  // one data-port word moved
    logic cntDec;    // one sector finished cleanly
    logic addrAdv;   // move to next sector address
  } dpStrobe_t;

endpackage

// File: rtl/pss_dpath.sv
module pss_dpath
  import pss_pkg::*;
#(
  parameter int SEC_W            = 8,
  parameter int HEAD_W           = 4,
  parameter int CYL_W            = 16,
  parameter int WORDS_PER_SECTOR = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         stb,
  input  logic [SEC_W-1:0]  startSecCnt,
  input  logic [SEC_W-1:0]  startSector,
  input  logic [HEAD_W-1:0] startHead,
  input  logic [CYL_W-1:0]  startCyl,
  input  logic [SEC_W-1:0]  maxSector,
  input  logic [HEAD_W-1:0] maxHead,
  output logic [SEC_W-1:0]  secCntOut,
  output logic [SEC_W-1:0]  sectorOut,
  output logic [HEAD_W-1:0] headOut,
  output logic [CYL_W-1:0]  cylOut,
  output logic [$clog2(WORDS_PER_SECTOR)-1:0] wordAddr,
  output logic              wordLast,
  output logic              cntLast
);

  localparam int CNT_W  = SEC_W + 1;
  localparam int WORD_W = $clog2(WORDS_PER_SECTOR);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(1) << SEC_W;
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [WORD_W-1:0] WORD_MAX = WORD_W'(WORDS_PER_SECTOR - 1);
  localparam logic [SEC_W-1:0]  SEC_ONE  = SEC_W'(1);
  localparam logic [HEAD_W-1:0] HEAD_ONE = HEAD_W'(1);
  localparam logic [CYL_W-1:0]  CYL_ONE  = CYL_W'(1);

  logic [CNT_W-1:0]  remCnt;
  logic [WORD_W-1:0] wordCnt;
  logic [SEC_W-1:0]  sectorQ;
  logic [HEAD_W-1:0] headQ;
  logic [CYL_W-1:0]  cylQ;

  logic              secWrap;
  logic              headWrap;
  logic [SEC_W-1:0]  sectorNxt;
  logic [HEAD_W-1:0] headNxt;
  logic [CYL_W-1:0]  cylNxt;

  // next sector address: sector, then head, then cylinder
  always_comb begin
    secWrap   = (sectorQ >= maxSector);
    headWrap  = (headQ >= maxHead);
    sectorNxt = secWrap ? SEC_ONE : sectorQ + SEC_ONE;
    headNxt   = headQ;
    cylNxt    = cylQ;
    if (secWrap) begin
      headNxt = headWrap ? '0 : headQ + HEAD_ONE;
      if (headWrap) cylNxt = cylQ + CYL_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remCnt  <= '0;
      sectorQ <= '0;
      headQ   <= '0;
      cylQ    <= '0;
    end else if (stb.load) begin
      remCnt  <= (startSecCnt == '0) ? CNT_FULL : {1'b0, startSecCnt};
      sectorQ <= startSector;
      headQ   <= startHead;
      cylQ    <= startCyl;
    end else begin
      if (stb.cntDec) remCnt <= remCnt - CNT_ONE;
      if (stb.addrAdv) begin
        sectorQ <= sectorNxt;
        headQ   <= headNxt;
        cylQ    <= cylNxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordCnt <= '0;
    end else if (stb.load) begin
      wordCnt <= '0;
    end else if (stb.wordStep) begin
      wordCnt <= (wordCnt == WORD_MAX) ? '0 : wordCnt + WORD_W'(1);
    end
  end

  assign wordLast  = (wordCnt == WORD_MAX);
  assign cntLast   = (remCnt == CNT_ONE);
  assign secCntOut = remCnt[SEC_W-1:0];
  assign sectorOut = sectorQ;
  assign headOut   = headQ;
  assign cylOut    = cylQ;
  assign wordAddr  = wordCnt;

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [1:0] cmdKind,
  input  logic       portRd,
  input  logic       portWr,
  input  logic       statusRd,
  input  logic       mediaDone,
  input  logic       mediaErr,
  input  logic       wordLast,
  input  logic       cntLast,
  output dpStrobe_t  stb,
  output logic       busy,
  output logic       drq,
  output logic       intrq,
  output logic       errFlag,
  output logic       mediaReq
);

  seqState_t state, stateNxt;
  cmdKind_t  kind;
  logic      accept;
  logic      intSet;
  logic      errSet;

  assign kind   = cmdKind_t'(cmdKind);
  assign accept = cmdValid && (state == ST_IDLE) && (kind != KIND_NONE);

  always_comb begin
    stateNxt = state;
    stb      = '0;
    intSet   = 1'b0;
    errSet   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          stb.load = 1'b1;
          case (kind)
            KIND_READ:   stateNxt = ST_RD_MEDIA;
            KIND_VERIFY: stateNxt = ST_VF_MEDIA;
            KIND_WRITE:  stateNxt = ST_WR_XFER;
            default:     stateNxt = ST_IDLE;
          endcase
        end
      end
      ST_RD_MEDIA: begin
        if (mediaDone) begin
          stateNxt = ST_RD_XFER;
          intSet   = 1'b1;
          errSet   = mediaErr;
        end
      end
      ST_RD_XFER: begin
        if (portRd) begin
          stb.wordStep = 1'b1;
          if (wordLast) begin
            if (errFlag) begin
              stateNxt = ST_IDLE;          // stop at failing sector
            end else begin
              stb.cntDec = 1'b1;
              if (cntLast) begin
                stateNxt = ST_IDLE;
              end else begin
                stb.addrAdv = 1'b1;
                stateNxt    = ST_RD_MEDIA;
              end
            end
          end
        end
      end
      ST_WR_XFER: begin
        if (portWr) begin
          stb.wordStep = 1'b1;
          if (wordLast) stateNxt = ST_WR_MEDIA;
        end
      end
      ST_WR_MEDIA: begin
        if (mediaDone) begin
          intSet = 1'b1;
          if (mediaErr) begin
            errSet   = 1'b1;
            stateNxt = ST_IDLE;
          end else begin
            stb.cntDec = 1'b1;
            if (cntLast) begin
              stateNxt = ST_IDLE;
            end else begin
              stb.addrAdv = 1'b1;
              stateNxt    = ST_WR_XFER;
            end
          end
        end
      end
      ST_VF_MEDIA: begin
        if (mediaDone) begin
          if (mediaErr) begin
            errSet   = 1'b1;
            intSet   = 1'b1;
            stateNxt = ST_IDLE;
          end else begin
            stb.cntDec = 1'b1;
            if (cntLast) begin
              intSet   = 1'b1;
              stateNxt = ST_IDLE;
            end else begin
              stb.addrAdv = 1'b1;
            end
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  // raise beats acknowledge when both land together
  always_ff @(posedge clk) begin
    if (!rst_n)                    intrq <= 1'b0;
    else if (intSet)               intrq <= 1'b1;
    else if (accept || statusRd)   intrq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      errFlag <= 1'b0;
    else if (accept) errFlag <= 1'b0;
    else if (errSet) errFlag <= 1'b1;
  end

  assign busy     = (state == ST_RD_MEDIA) || (state == ST_WR_MEDIA) ||
                    (state == ST_VF_MEDIA);
  assign drq      = (state == ST_RD_XFER) || (state == ST_WR_XFER);
  assign mediaReq = busy;

endmodule

// File: rtl/pio_sector_seq.sv
module pio_sector_seq
  import pss_pkg::*;
#(
  parameter int SEC_W            = 8,
  parameter int HEAD_W           = 4,
  parameter int CYL_W            = 16,
  parameter int WORDS_PER_SECTOR = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic [1:0]        cmdKind,
  input  logic [SEC_W-1:0]  startSecCnt,
  input  logic [SEC_W-1:0]  startSector,
  input  logic [HEAD_W-1:0] startHead,
  input  logic [CYL_W-1:0]  startCyl,
  input  logic [SEC_W-1:0]  maxSector,
  input  logic [HEAD_W-1:0] maxHead,
  input  logic              portRd,
  input  logic              portWr,
  input  logic              statusRd,
  input  logic              mediaDone,
  input  logic              mediaErr,
  output logic              mediaReq,
  output logic              busy,
  output logic              drq,
  output logic              intrq,
  output logic              errFlag,
  output logic [SEC_W-1:0]  secCntOut,
  output logic [SEC_W-1:0]  sectorOut,
  output logic [HEAD_W-1:0] headOut,
  output logic [CYL_W-1:0]  cylOut,
  output logic [$clog2(WORDS_PER_SECTOR)-1:0] bufAddr
);

  dpStrobe_t stb;
  logic      wordLast;
  logic      cntLast;

  pss_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmdValid  (cmdValid),
    .cmdKind   (cmdKind),
    .portRd    (portRd),
    .portWr    (portWr),
    .statusRd  (statusRd),
    .mediaDone (mediaDone),
    .mediaErr  (mediaErr),
    .wordLast  (wordLast),
    .cntLast   (cntLast),
    .stb       (stb),
    .busy      (busy),
    .drq       (drq),
    .intrq     (intrq),
    .errFlag   (errFlag),
    .mediaReq  (mediaReq)
  );

  pss_dpath #(
    .SEC_W            (SEC_W),
    .HEAD_W           (HEAD_W),
    .CYL_W            (CYL_W),
    .WORDS_PER_SECTOR (WORDS_PER_SECTOR)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .startSecCnt (startSecCnt),
    .startSector (startSector),
    .startHead   (startHead),
    .startCyl    (startCyl),
    .maxSector   (maxSector),
    .maxHead     (maxHead),
    .secCntOut   (secCntOut),
    .sectorOut   (sectorOut),
    .headOut     (headOut),
    .cylOut      (cylOut),
    .wordAddr    (bufAddr),
    .wordLast    (wordLast),
    .cntLast     (cntLast)
  );

endmodule

// File: rtl/pio_sector_seq_chk.sv
module pio_sector_seq_chk #(
  parameter int SEC_W  = 8,
  parameter int WORD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmdValid,
  input logic             busy,
  input logic             drq,
  input logic             intrq,
  input logic             errFlag,
  input logic [SEC_W-1:0] secCntOut,
  input logic [SEC_W-1:0] sectorOut,
  input logic [WORD_W-1:0] bufAddr
);

  localparam logic [SEC_W-1:0] ONE = SEC_W'(1);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || drq) |=> (secCntOut == $past(secCntOut) ||
                       secCntOut == $past(secCntOut) - ONE)); // R1

  AST_INT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intrq) |-> !busy); // R2

  AST_ERR_WITH_INT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errFlag) |-> intrq); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !drq && !cmdValid) |=> ($stable(secCntOut) && $stable(sectorOut))); // R6

  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !drq |=> $stable(bufAddr)); // R9

endmodule

bind pio_sector_seq pio_sector_seq_chk #(
  .SEC_W  (SEC_W),
  .WORD_W ($clog2(WORDS_PER_SECTOR))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmdValid  (cmdValid),
  .busy      (busy),
  .drq       (drq),
  .intrq     (intrq),
  .errFlag   (errFlag),
  .secCntOut (secCntOut),
  .sectorOut (sectorOut),
  .bufAddr   (bufAddr)
);

// File: tb/pio_sector_seq_bench.sv
module pio_sector_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdKind = 2'd3;
  logic [7:0]  startSecCnt = '0, startSector = '0, maxSector = '0;
  logic [3:0]  startHead = '0, maxHead = '0;
  logic [15:0] startCyl = '0;
  logic        portRd = 1'b0, portWr = 1'b0, statusRd = 1'b0;
  logic        mediaDone = 1'b0, mediaErr = 1'b0;
  logic        mediaReq, busy, drq, intrq, errFlag;
  logic [7:0]  secCntOut, sectorOut, bufAddr;
  logic [3:0]  headOut;
  logic [15:0] cylOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pio_sector_seq u_pio_sector_seq (.*);

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  sc;
    logic [7:0]  sn;
    logic [3:0]  hd;
    logic [15:0] cy;
    logic [7:0]  ms;
    logic [3:0]  mh;
    logic [8:0]  errAt;   // 1-based sector index that fails, 0 none
    logic [7:0]  xSc;
    logic [7:0]  xSn;
    logic [3:0]  xHd;
    logic [15:0] xCy;
    logic        xErr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd3, 8'd1,  4'd0, 16'h0005, 8'd17, 4'd3, 9'd0, 8'd0, 8'd3,  4'd0, 16'h0005, 1'b0},
    '{2'd0, 8'd2, 8'd17, 4'd3, 16'h00FF, 8'd17, 4'd3, 9'd0, 8'd0, 8'd1,  4'd0, 16'h0100, 1'b0},
    '{2'd0, 8'd4, 8'd16, 4'd1, 16'h0009, 8'd17, 4'd3, 9'd3, 8'd2, 8'd1,  4'd2, 16'h0009, 1'b1},
    '{2'd2, 8'd3, 8'd5,  4'd0, 16'h0002, 8'd17, 4'd3, 9'd0, 8'd0, 8'd7,  4'd0, 16'h0002, 1'b0},
    '{2'd2, 8'd3, 8'd5,  4'd0, 16'h0002, 8'd17, 4'd3, 9'd2, 8'd2, 8'd6,  4'd0, 16'h0002, 1'b1},
    '{2'd1, 8'd0, 8'd1,  4'd0, 16'h0000, 8'd17, 4'd3, 9'd0, 8'd0, 8'd1,  4'd3, 16'h0003, 1'b0},
    '{2'd1, 8'd5, 8'd2,  4'd1, 16'h0007, 8'd8,  4'd1, 9'd5, 8'd1, 8'd6,  4'd1, 16'h0007, 1'b1},
    '{2'd2, 8'd1, 8'd8,  4'd1, 16'hFFFF, 8'd8,  4'd1, 9'd0, 8'd0, 8'd8,  4'd1, 16'hFFFF, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doneP(input logic e);
    mediaDone = 1'b1; mediaErr = e;
    tick();
    mediaDone = 1'b0; mediaErr = 1'b0;
  endtask

  task automatic portN(input bit wr, input int n);
    if (wr) portWr = 1'b1; else portRd = 1'b1;
    repeat (n) tick();
    portWr = 1'b0; portRd = 1'b0;
  endtask

  task automatic statP();
    statusRd = 1'b1;
    tick();
    statusRd = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] sc, input logic [7:0] sn,
                       input logic [3:0] hd, input logic [15:0] cy,
                       input logic [7:0] ms, input logic [3:0] mh);
    cmdKind = k; startSecCnt = sc; startSector = sn; startHead = hd;
    startCyl = cy; maxSector = ms; maxHead = mh;
    cmdValid = 1'b1;
    tick();
    cmdValid = 1'b0;
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int  n;
    bit  stop;
    bit  isErr;
    bit  last;
    n = (v.sc == 0) ? 256 : int'(v.sc);
    stop = 1'b0;
    issue(v.kind, v.sc, v.sn, v.hd, v.cy, v.ms, v.mh);
    for (int i = 1; i <= n && !stop; i++) begin
      isErr = (i == int'(v.errAt));
      last  = (i == n);
      case (v.kind)
        2'd0: begin
          chk($sformatf("R2 v%0d s%0d rd busy", idx, i), {drq, busy}, 2'b01);
          doneP(isErr);
          chk($sformatf("R2 v%0d s%0d rd drq/int", idx, i), {busy, drq, intrq}, 3'b011);
          if (isErr) chk($sformatf("R5 v%0d rd err", idx), errFlag, 1'b1);
          statP();
          chk($sformatf("R11 v%0d s%0d ack", idx, i), intrq, 1'b0);
          portN(1'b0, 256);
          if (isErr || last) begin
            chk($sformatf("R2 v%0d end flags", idx), {busy, drq}, 2'b00);
            stop = 1'b1;
          end else begin
            chk($sformatf("R2 v%0d s%0d rebusy", idx, i), {busy, drq}, 2'b10);
          end
        end
        2'd2: begin
          chk($sformatf("R3 v%0d s%0d wr drq", idx, i), {busy, drq, intrq},
              {2'b01, (i == 1) ? 1'b0 : 1'b1});
          if (i > 1) statP();
          portN(1'b1, 256);
          chk($sformatf("R3 v%0d s%0d wr busy", idx, i), {busy, drq}, 2'b10);
          doneP(isErr);
          if (isErr || last) begin
            chk($sformatf("R3 R5 v%0d wr end", idx), {busy, drq, intrq}, 3'b001);
            stop = 1'b1;
          end
        end
        default: begin
          chk($sformatf("R4 v%0d s%0d vf busy", idx, i), {busy, drq}, 2'b10);
          doneP(isErr);
          if (isErr || last) begin
            chk($sformatf("R4 v%0d vf end", idx), {busy, drq, intrq}, 3'b001);
            stop = 1'b1;
          end else begin
            chk($sformatf("R4 v%0d s%0d vf quiet", idx, i), {drq, intrq}, 2'b00);
          end
        end
      endcase
    end
    chk($sformatf("R1 R5 v%0d count", idx), secCntOut, v.xSc);
    chk($sformatf("R6 R7 v%0d sector", idx), sectorOut, v.xSn);
    chk($sformatf("R6 R7 v%0d head", idx), headOut, v.xHd);
    chk($sformatf("R6 R7 v%0d cyl", idx), cylOut, v.xCy);
    chk($sformatf("R5 v%0d err", idx), errFlag, v.xErr);
    statP();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    chk("R12 flags", {busy, drq, intrq, errFlag, mediaReq}, 5'b0);
    chk("R12 taskfile", {secCntOut, sectorOut, headOut, cylOut}, 36'h0);
    chk("R12 bufAddr", bufAddr, 8'h0);

    for (int k = 0; k < NV; k++) runVec(VECS[k], k);

    // R9 R10 R8 R11: ignored accesses, word index, same-cycle raise and ack
    issue(2'd0, 8'd2, 8'd1, 4'd0, 16'h0, 8'd17, 4'd3);
    portN(1'b0, 5);
    portN(1'b1, 3);
    issue(2'd2, 8'd9, 8'd4, 4'd1, 16'h1, 8'd17, 4'd3);
    chk("R10 cmd while busy", {busy, drq, secCntOut}, {2'b10, 8'd2});
    chk("R10 addr kept", sectorOut, 8'd1);
    statusRd = 1'b1;
    doneP(1'b0);
    statusRd = 1'b0;
    chk("R11 raise wins over ack", intrq, 1'b1);
    chk("R9 reads while busy ignored", bufAddr, 8'd0);
    statP();
    chk("R11 ack clears", intrq, 1'b0);
    portN(1'b1, 4);
    chk("R9 wrong direction ignored", bufAddr, 8'd0);
    portN(1'b0, 10);
    chk("R8 word index", bufAddr, 8'd10);
    portN(1'b0, 246);
    chk("R1 count after first", {busy, secCntOut}, {1'b1, 8'd1});
    chk("R7 next sector", sectorOut, 8'd2);
    doneP(1'b0);
    statP();
    portN(1'b0, 256);
    chk("R1 R6 read done", {busy, drq, secCntOut, sectorOut}, {2'b00, 8'd0, 8'd2});
    portN(1'b0, 7);
    chk("R9 idle reads ignored", {bufAddr, sectorOut}, {8'd0, 8'd2});

    // R11 command clears a pending interrupt
    issue(2'd1, 8'd1, 8'd3, 4'd0, 16'h0, 8'd17, 4'd3);
    doneP(1'b0);
    chk("R4 verify int", intrq, 1'b1);
    issue(2'd1, 8'd1, 8'd4, 4'd0, 16'h0, 8'd17, 4'd3);
    chk("R11 command clears int", {busy, intrq}, 2'b10);
    doneP(1'b0);
    statP();

    // R10 kind code 3 ignored
    issue(2'd3, 8'd5, 8'd9, 4'd2, 16'h33, 8'd17, 4'd3);
    chk("R10 kind3 ignored", {busy, drq, secCntOut, sectorOut}, {2'b00, 8'd0, 8'd4});

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule